// File: doc/BRIEF.md
# Interrupt Level Controller

This block gathers thirteen level-sensitive peripheral requests into a 32-bit pending-status word. Each request has a fixed bit in that word, and the bits are spread across it. A 32-bit enable word selects which pending bits may reach the processor. From the enabled pending bits the block forms a processor priority level and an autovector number. There are three groups: a top group at level 6, a single serial source at level 5, and a general group at level 3.

Software reaches both words through a small register port. Reads are combinational. A write lands on the next clock edge and replaces the whole word, so software can both set and clear pending bits. A source changes its status bit only when its request line changes. Because of this, a software write stays in place while the request line holds still.

Two side inputs come from neighbouring logic:
- A write of the storage-bus DMA control byte copies one of its bits into the storage-DMA status bit.
- A single-cycle pulse from the clock/power block clears the power-fail status bit.

Top module: `irq_level_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status word and the enable word are both 0, and `irq_level`/`irq_vector` are 0.
- R2: A rising edge on `src_req[i]` sets status bit B(i) on the next clock. The index-to-bit map is: 0→7, 1→3, 2→2, 3→9, 4→10, 5→12, 6→5, 7→17, 8→28, 9→27, 10→26, 11→23, 12→21.
- R3: A falling edge on `src_req[i]` clears status bit B(i) on the next clock. A request held at a steady level leaves the bit alone.
- R4: A write with `reg_addr` = 0x7000 replaces the whole status word on the next clock. Reading that offset returns the status word in the same cycle.
- R5: Offset 0x7800 holds the enable word and can be read and written. Every other offset reads as 0, and a write to any other offset changes neither word.
- R6: When `dma_ctl_we` is high, bit 4 of `dma_ctl_byte` is copied into status bit 26. A 1 sets the bit and a 0 clears it.
- R7: A `pwr_clr` pulse clears status bit 2 on the next clock.
- R8: Each bit has a fixed precedence within one cycle. A source edge beats the side inputs (`dma_ctl_we`, `pwr_clr`), and the side inputs beat a register write. Bits without a same-cycle edge or side input take the written value.
- R9: Pending means status AND enable. The outputs are chosen as follows:
  - Any pending bit among {21,23,26,27,28} gives level 6 with vector 30.
  - Otherwise, pending bit 17 gives level 5 with vector 29.
  - Otherwise, any pending bit among {2,3,5,7,9,10,12} gives level 3 with vector 27.
- R10: With no pending bit in any group, the level and the vector are both 0. This also holds when unmapped status bits are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 13 | Peripheral request levels, index map in R2 |
| reg_addr | input | 16 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dma_ctl_we | input | 1 | Storage-bus DMA control byte write strobe |
| dma_ctl_byte | input | 8 | Storage-bus DMA control byte value |
| pwr_clr | input | 1 | Power-fail status clear pulse |
| irq_level | output | 3 | Encoded processor priority level |
| irq_vector | output | 8 | Autovector number |

## Verification
A source edge can land in the same cycle as a side input or a register write on the same status bit. The bench provokes three such collisions:
- a power-source rise together with `pwr_clr`;
- a storage-DMA source rise together with a control-byte write that clears bit 26;
- a status-word write together with a floppy-source rise.

In each collision, the status read back afterwards must show the edge winning on its own bit while the written value holds on all other bits. A behavioural reference model predicts the status word, the enable word, the read data, the level and the vector every cycle.

// File: rtl/irqc_pkg.sv
// Shared constants for the interrupt level controller: the source-to-bit
// map, level grouping, vector numbers and helper constant functions.
// Assumes a 32-bit status word; all tables are indexed by source number.
package irqc_pkg;

    localparam int NSRC  = 13;
    localparam int DW    = 32;
    localparam int LVL_W = 3;
    localparam int VEC_W = 8;

    // status bit owned by each source index
    localparam int SRC_BIT [NSRC] = '{7, 3, 2, 9, 10, 12, 5, 17, 28, 27, 26, 23, 21};
    // processor level each source index belongs to
    localparam int SRC_LVL [NSRC] = '{3, 3, 3, 3, 3, 3, 3, 5, 6, 6, 6, 6, 6};

    localparam int PWR_BIT     = 2;
    localparam int DMA_BIT     = 26;
    localparam int CTL_DMA_SEL = 4;

    localparam logic [LVL_W-1:0] LVL_HI  = 3'd6;
    localparam logic [LVL_W-1:0] LVL_MID = 3'd5;
    localparam logic [LVL_W-1:0] LVL_LO  = 3'd3;
    localparam logic [VEC_W-1:0] VEC_HI  = 8'd30;
    localparam logic [VEC_W-1:0] VEC_MID = 8'd29;
    localparam logic [VEC_W-1:0] VEC_LO  = 8'd27;

    // Collect the status bits of every source in a given level group.
    function automatic logic [DW-1:0] grp_mask(input int lvl);
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (SRC_LVL[i] == lvl) m[SRC_BIT[i]] = 1'b1;
        end
        return m;
    endfunction

    // Return the source index owning status bit b, or -1 when unmapped.
    function automatic int src_of_bit(input int b);
        int r;
        r = -1;
        for (int i = 0; i < NSRC; i++) begin
            if (SRC_BIT[i] == b) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_edge.sv
// Edge detector for the request lines. Flags a rise or a fall for one cycle
// when a line differs from its registered copy.
// Assumes the request lines are already synchronous to clk.
module irqc_edge #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] prev_q;

    // remember last cycle's request levels
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        assign rise[g] = lvl[g] & ~prev_q[g];
        assign fall[g] = ~lvl[g] & prev_q[g];
    end

endmodule

// File: rtl/irqc_regs.sv
// Register port: decodes the offset, holds the enable word and returns
// read data combinationally. Produces the status write strobe for the
// status module. Assumes one access per cycle; unknown offsets read 0.
module irqc_regs #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] STAT_OFF = 16'h7000,
    parameter logic [ADDR_W-1:0] MASK_OFF = 16'h7800
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_we,
    input  logic [irqc_pkg::DW-1:0] reg_wdata,
    input  logic [irqc_pkg::DW-1:0] status_q,
    output logic                  stat_we,
    output logic [irqc_pkg::DW-1:0] mask_q,
    output logic [irqc_pkg::DW-1:0] reg_rdata
);

    logic hit_stat, hit_mask;

    assign hit_stat = (reg_addr == STAT_OFF);
    assign hit_mask = (reg_addr == MASK_OFF);
    assign stat_we  = reg_we & hit_stat;

    // enable word register
    always_ff @(posedge clk) begin
        if (!rst_n)                  mask_q <= '0;
        else if (reg_we && hit_mask) mask_q <= reg_wdata;
    end

    // read data selection
    always_comb begin
        if (hit_stat)      reg_rdata = status_q;
        else if (hit_mask) reg_rdata = mask_q;
        else               reg_rdata = '0;
    end

endmodule

// File: rtl/irqc_status.sv
// Status word. Per bit, precedence runs: source edge, then side input,
// then register write, then hold. Mapped bits come from the package table.
// Assumes rise/fall are one-cycle flags from the edge detector.
module irqc_status
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stat_we,
    input  logic [DW-1:0]   wdata,
    input  logic [NSRC-1:0] rise,
    input  logic [NSRC-1:0] fall,
    input  logic            dma_we,
    input  logic            dma_val,
    input  logic            pwr_clr,
    output logic [DW-1:0]   status_q
);

    logic [DW-1:0] status_d;

    for (genvar b = 0; b < DW; b++) begin : g_bit
        localparam int SIDX = src_of_bit(b);
        logic base_b, side_b;

        assign base_b = stat_we ? wdata[b] : status_q[b];

        if (b == DMA_BIT) begin : g_dma
            assign side_b = dma_we ? dma_val : base_b;
        end else if (b == PWR_BIT) begin : g_pwr
            assign side_b = pwr_clr ? 1'b0 : base_b;
        end else begin : g_plain
            assign side_b = base_b;
        end

        if (SIDX >= 0) begin : g_src
            assign status_d[b] = rise[SIDX] ? 1'b1 :
                                 fall[SIDX] ? 1'b0 : side_b;
        end else begin : g_sw
            assign status_d[b] = side_b;
        end
    end

    // status word register
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

endmodule

// File: rtl/irqc_prio.sv
// Priority encoder: masks the status word and picks the highest level group
// with a pending bit, with that group's vector. Unmapped bits never count.
// Assumes group membership is fixed by the package table.
module irqc_prio
    import irqc_pkg::*;
(
    input  logic [DW-1:0]    status_q,
    input  logic [DW-1:0]    mask_q,
    output logic [LVL_W-1:0] irq_level,
    output logic [VEC_W-1:0] irq_vector
);

    localparam logic [DW-1:0] M_HI  = grp_mask(6);
    localparam logic [DW-1:0] M_MID = grp_mask(5);
    localparam logic [DW-1:0] M_LO  = grp_mask(3);

    logic [DW-1:0] pend;
    assign pend = status_q & mask_q;

    // highest enabled group wins
    always_comb begin
        if (|(pend & M_HI)) begin
            irq_level  = LVL_HI;
            irq_vector = VEC_HI;
        end else if (|(pend & M_MID)) begin
            irq_level  = LVL_MID;
            irq_vector = VEC_MID;
        end else if (|(pend & M_LO)) begin
            irq_level  = LVL_LO;
            irq_vector = VEC_LO;
        end else begin
            irq_level  = '0;
            irq_vector = '0;
        end
    end

endmodule

// File: rtl/irq_level_ctrl.sv
// Top of the interrupt level controller. Wires the edge detector, status
// word, register port and priority encoder together.
// Assumes all inputs are synchronous to clk.
module irq_level_ctrl
    import irqc_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] STAT_OFF = 16'h7000,
    parameter logic [ADDR_W-1:0] MASK_OFF = 16'h7800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_req,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              dma_ctl_we,
    input  logic [7:0]        dma_ctl_byte,
    input  logic              pwr_clr,
    output logic [LVL_W-1:0]  irq_level,
    output logic [VEC_W-1:0]  irq_vector
);

    logic [NSRC-1:0] rise, fall;
    logic [DW-1:0]   status_q, mask_q;
    logic            stat_we;

    irqc_edge #(.N(NSRC)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (src_req),
        .rise  (rise),
        .fall  (fall)
    );

    irqc_regs #(.ADDR_W(ADDR_W), .STAT_OFF(STAT_OFF), .MASK_OFF(MASK_OFF)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .status_q  (status_q),
        .stat_we   (stat_we),
        .mask_q    (mask_q),
        .reg_rdata (reg_rdata)
    );

    irqc_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_we  (stat_we),
        .wdata    (reg_wdata),
        .rise     (rise),
        .fall     (fall),
        .dma_we   (dma_ctl_we),
        .dma_val  (dma_ctl_byte[CTL_DMA_SEL]),
        .pwr_clr  (pwr_clr),
        .status_q (status_q)
    );

    irqc_prio u_prio (
        .status_q   (status_q),
        .mask_q     (mask_q),
        .irq_level  (irq_level),
        .irq_vector (irq_vector)
    );

endmodule

// File: rtl/irq_level_ctrl_chk.sv
// Property checker for the interrupt level controller, bound to the top.
// Watches the ports and the status and enable words.
module irq_level_ctrl_chk
    import irqc_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] MASK_OFF = 16'h7800
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   src_req,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [DW-1:0]     reg_wdata,
    input logic              dma_ctl_we,
    input logic [7:0]        dma_ctl_byte,
    input logic              pwr_clr,
    input logic [LVL_W-1:0]  irq_level,
    input logic [VEC_W-1:0]  irq_vector,
    input logic [DW-1:0]     status_q,
    input logic [DW-1:0]     mask_q
);

    for (genvar i = 0; i < NSRC; i++) begin : g_src_chk
        localparam int B = SRC_BIT[i];
        AST_SRC_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $rose(src_req[i]) |=> status_q[B]); // R2
        AST_SRC_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $fell(src_req[i]) |=> !status_q[B]); // R3
    end

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_addr == MASK_OFF |=> mask_q == $past(reg_wdata)); // R5

    AST_DMA_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && dma_ctl_we && $stable(src_req[10])
        |=> status_q[DMA_BIT] == $past(dma_ctl_byte[CTL_DMA_SEL])); // R6

    AST_PWR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && pwr_clr && $stable(src_req[2]) |=> !status_q[PWR_BIT]); // R7

    AST_PWR_RACE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_clr && $rose(src_req[2]) |=> status_q[PWR_BIT]); // R8

    AST_VEC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == 3'd6) == (irq_vector == 8'd30)); // R9

    AST_NO_ENABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q == '0 |-> irq_level == '0 && irq_vector == '0); // R10

endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.ADDR_W(ADDR_W), .MASK_OFF(MASK_OFF)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_req      (src_req),
    .reg_addr     (reg_addr),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .dma_ctl_we   (dma_ctl_we),
    .dma_ctl_byte (dma_ctl_byte),
    .pwr_clr      (pwr_clr),
    .irq_level    (irq_level),
    .irq_vector   (irq_vector),
    .status_q     (status_q),
    .mask_q       (mask_q)
);

// File: tb/irq_level_ctrl_test.sv
// Bench: behavioural reference model compared every clock, plus directed
// checks of each requirement.
module irq_level_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_STAT = 16'h7000;
    localparam logic [15:0] A_MASK = 16'h7800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] src_req = '0;
    logic [15:0] reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dma_ctl_we = 1'b0;
    logic [7:0]  dma_ctl_byte = '0;
    logic        pwr_clr = 1'b0;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    irq_level_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dma_ctl_we(dma_ctl_we), .dma_ctl_byte(dma_ctl_byte), .pwr_clr(pwr_clr),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int bitpos(int i);
        case (i)
            0: return 7;   1: return 3;   2: return 2;   3: return 9;
            4: return 10;  5: return 12;  6: return 5;   7: return 17;
            8: return 28;  9: return 27;  10: return 26; 11: return 23;
            default: return 21;
        endcase
    endfunction

    // reference model state
    logic [31:0] m_st = '0, m_mk = '0;
    logic [12:0] m_prev = '0;

    always @(posedge clk) begin
        logic [31:0] ns;
        if (!rst_n) begin
            m_st = '0; m_mk = '0; m_prev = '0;
        end else begin
            ns = m_st;
            if (reg_we && reg_addr == A_STAT) ns = reg_wdata;
            if (reg_we && reg_addr == A_MASK) m_mk = reg_wdata;
            if (dma_ctl_we) ns[26] = dma_ctl_byte[4];
            if (pwr_clr) ns[2] = 1'b0;
            for (int i = 0; i < 13; i++) begin
                if (src_req[i] && !m_prev[i]) ns[bitpos(i)] = 1'b1;
                else if (!src_req[i] && m_prev[i]) ns[bitpos(i)] = 1'b0;
            end
            m_prev = src_req;
            m_st = ns;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        logic [31:0] p, er;
        logic [2:0]  el;
        logic [7:0]  ev;
        if (rst_n && !done) begin
            p = m_st & m_mk;
            if (p & ((1<<28)|(1<<27)|(1<<26)|(1<<23)|(1<<21))) begin el = 6; ev = 30; end
            else if (p & (1<<17)) begin el = 5; ev = 29; end
            else if (p & ((1<<7)|(1<<3)|(1<<2)|(1<<9)|(1<<10)|(1<<12)|(1<<5))) begin el = 3; ev = 27; end
            else begin el = 0; ev = 0; end
            er = (reg_addr == A_STAT) ? m_st : (reg_addr == A_MASK) ? m_mk : 32'h0;
            chk("R9 model level", {29'h0, irq_level}, {29'h0, el});
            chk("R9 model vector", {24'h0, irq_vector}, {24'h0, ev});
            chk("R4 model rdata", reg_rdata, er);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, logic [31:0] exp, string tag);
        reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
        tick();
    endtask

    task automatic lv(logic [2:0] el, logic [7:0] ev, string tag);
        @(negedge clk);
        chk(tag, {29'h0, irq_level}, {29'h0, el});
        chk(tag, {24'h0, irq_vector}, {24'h0, ev});
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        rd(A_STAT, 32'h0, "R1 status");
        rd(A_MASK, 32'h0, "R1 mask");
        lv(3'd0, 8'd0, "R1 outputs");
        // R5 enable word
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, 32'hFFFF_FFFF, "R5 mask rw");
        // R2 / R3 each source
        for (int i = 0; i < 13; i++) begin
            src_req[i] = 1'b1; tick();
            rd(A_STAT, 32'h1 << bitpos(i), "R2 source bit");
            lv((i <= 6) ? 3'd3 : (i == 7) ? 3'd5 : 3'd6,
               (i <= 6) ? 8'd27 : (i == 7) ? 8'd29 : 8'd30, "R9 group");
            src_req[i] = 1'b0; tick();
            rd(A_STAT, 32'h0, "R3 fall clears");
        end
        // R4 whole-word write
        wr(A_STAT, 32'h0000_0F00);
        rd(A_STAT, 32'h0000_0F00, "R4 status write");
        src_req[5] = 1'b1; tick();
        wr(A_STAT, 32'h0);
        tick();
        rd(A_STAT, 32'h0, "R3 steady level holds write");
        src_req[5] = 1'b0; tick();
        // R5 other offsets
        wr(16'h1234, 32'hDEAD_BEEF);
        rd(16'h1234, 32'h0, "R5 unmapped read");
        rd(A_MASK, 32'hFFFF_FFFF, "R5 mask untouched");
        rd(A_STAT, 32'h0, "R5 status untouched");
        // R6 DMA control byte
        dma_ctl_we = 1'b1; dma_ctl_byte = 8'h10; tick(); dma_ctl_we = 1'b0;
        rd(A_STAT, 32'h0400_0000, "R6 set");
        lv(3'd6, 8'd30, "R6 level");
        dma_ctl_we = 1'b1; dma_ctl_byte = 8'hEF; tick(); dma_ctl_we = 1'b0;
        rd(A_STAT, 32'h0, "R6 clear");
        // R7 power clear
        wr(A_STAT, 32'h4);
        rd(A_STAT, 32'h4, "R7 preset");
        pwr_clr = 1'b1; tick(); pwr_clr = 1'b0;
        rd(A_STAT, 32'h0, "R7 clear");
        // R8 collisions
        pwr_clr = 1'b1; src_req[2] = 1'b1; tick(); pwr_clr = 1'b0;
        rd(A_STAT, 32'h4, "R8 edge beats pwr_clr");
        src_req[2] = 1'b0; tick();
        dma_ctl_we = 1'b1; dma_ctl_byte = 8'h00; src_req[10] = 1'b1; tick(); dma_ctl_we = 1'b0;
        rd(A_STAT, 32'h0400_0000, "R8 edge beats dma byte");
        src_req[10] = 1'b0; tick();
        reg_addr = A_STAT; reg_wdata = 32'h0002_0000; reg_we = 1'b1; src_req[0] = 1'b1;
        tick(); reg_we = 1'b0;
        rd(A_STAT, 32'h0002_0080, "R8 edge beats write");
        src_req[0] = 1'b0; tick();
        wr(A_STAT, 32'h0);
        // R9 priority
        wr(A_STAT, (32'h1 << 7) | (32'h1 << 17) | (32'h1 << 23));
        lv(3'd6, 8'd30, "R9 top group");
        wr(A_MASK, ~(32'h1 << 23));
        lv(3'd5, 8'd29, "R9 serial group");
        wr(A_MASK, 32'h1 << 7);
        lv(3'd3, 8'd27, "R9 general group");
        // R10 nothing pending
        wr(A_MASK, 32'hFFFF_FFFF);
        wr(A_STAT, 32'h8000_0001);
        lv(3'd0, 8'd0, "R10 unmapped only");
        wr(A_STAT, 32'h1 << 17);
        wr(A_MASK, 32'h0);
        lv(3'd0, 8'd0, "R10 all masked");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule